// File: doc/BRIEF.md
# Programmable Duty SD Clock Generator

This block derives the clock for an SD-card interface from the system clock. A fast clock is built from two phase-length fields, one for the high part and one for the low part of each period. Each field holds the phase length in system cycles minus one, so the period and the duty cycle can both be set. For example, a high field of 3 and a low field of 0 give a period of five cycles at 80% duty. At a 250 MHz system clock that makes a 50 MHz SD clock. The intended range for the fast clock is 25 to 50 MHz.

For card initialisation a slow mode is selected. In slow mode the fast clock keeps running inside the block, and the output becomes a square wave that toggles after half of a programmable count of fast-clock periods. A count of 50 brings a 50 MHz fast clock down to about 1 MHz.

The block changes settings only at a rising edge of its clock, so the output never carries a runt pulse. It also reports every output edge with a strobe one system cycle wide, which lets neighbouring logic launch and capture card signals without an edge detector of its own.

Top module: `sdclk_duty_gen`

## Requirements
- R1: While reset is asserted and after its release, `sd_clk`, `rise_stb` and `fall_stb` are 0 until `en` is sampled high.
- R2: When the generator is idle and `en` is sampled high at a clock edge, `sd_clk` is 1 and `rise_stb` is 1 from that edge on. The first high phase therefore starts one register stage after `en` is sampled.
- R3: In normal mode (`slow_sel` = 0), `sd_clk` stays high for `hi_len`+1 system cycles and low for `lo_len`+1 system cycles. Each field is 4 bits wide, with a range of 0 to 15.
- R4: `rise_stb` is 1 for exactly the one cycle in which `sd_clk` has just gone from 0 to 1. `fall_stb` is 1 for exactly the one cycle in which `sd_clk` has just gone from 1 to 0. The two strobes are never 1 in the same cycle.
- R5: A change of `hi_len` or `lo_len` made during a period does not alter that period. The new lengths take effect from the next rising edge.
- R6: In slow mode (`slow_sel` = 1), the high time and the low time of `sd_clk` each equal H × (`hi_len` + `lo_len` + 2) system cycles, where H = floor(`slow_div`/2).
- R7: `slow_sel` and `slow_div` are sampled only at a rising edge of `sd_clk`. A mode change made during a period lets that period finish in the old mode.
- R8: When `en` is deasserted, the current high phase is completed at its full length (in slow mode, the full slow half period). `sd_clk` then stays low and no further rising edge occurs while `en` stays low.
- R9: A `slow_div` of 0 or 1 is treated as H = 1, so the slow output toggles on every fast-clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run request for the SD clock |
| slow_sel | input | 1 | 0 = normal fast clock, 1 = slow initialisation clock |
| hi_len | input | PH_W | High phase length minus one, in system cycles |
| lo_len | input | PH_W | Low phase length minus one, in system cycles |
| slow_div | input | DIV_W | Slow-mode divide count in fast periods (toggle after half) |
| sd_clk | output | 1 | Generated SD clock |
| rise_stb | output | 1 | One-cycle strobe on each rising edge of `sd_clk` |
| fall_stb | output | 1 | One-cycle strobe on each falling edge of `sd_clk` |

## Verification
The assertions make no assumption about how the phase fields, `slow_sel` or `slow_div` move. The block samples them only at a rising edge, so they may change in any cycle. The stimulus depends on this: it changes the fields and the mode at the negative clock edge just after a rising strobe, which is mid-period and the case most likely to produce a runt. The one assumption is that `en` is a clean synchronous level. The bench drives it only at negative edges and holds it for many periods, so that every start and stop condition is seen from both the idle and the running state.

// File: rtl/sdcg_pkg.sv
package sdcg_pkg;
   typedef enum logic {
      SDCG_FAST = 1'b0,
      SDCG_SLOW = 1'b1
   } sdcg_mode_e;
endpackage

// File: rtl/sdcg_phase_gen.sv
// Fast clock phase engine: high for hi+1 cycles, low for lo+1 cycles.
// Exposes next-edge decisions so the output stage can update on the same edge.
module sdcg_phase_gen #(
   parameter int PH_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [PH_W-1:0] hi_len,
   input  logic [PH_W-1:0] lo_len,
   output logic            fclk,
   output logic            busy,
   output logic            rise_nxt,
   output logic            fall_nxt
);
   logic [PH_W-1:0] cnt_q, hi_a, lo_a;
   logic            lo_done, stop_nxt;

   if (PH_W < 1) begin : g_bad_ph_w
      $error("sdcg_phase_gen: PH_W must be at least 1");
   end

   assign lo_done  = busy && !fclk && (cnt_q == lo_a);
   assign rise_nxt = run && (!busy || lo_done);
   assign fall_nxt = busy && fclk && (cnt_q == hi_a);
   assign stop_nxt = lo_done && !run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fclk  <= 1'b0;
         busy  <= 1'b0;
         cnt_q <= '0;
         hi_a  <= '0;
         lo_a  <= '0;
      end else if (rise_nxt) begin
         fclk  <= 1'b1;
         busy  <= 1'b1;
         cnt_q <= '0;
         hi_a  <= hi_len;
         lo_a  <= lo_len;
      end else if (fall_nxt) begin
         fclk  <= 1'b0;
         cnt_q <= '0;
      end else if (stop_nxt) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (busy) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R3: the phase counter never passes the latched length of its phase
   p_hi_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && fclk) |-> (cnt_q <= hi_a));
   p_lo_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fclk) |-> (cnt_q <= lo_a));
   // R5: latched lengths move only when a new high phase starts
   p_len_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rise_nxt) |-> ($stable(hi_a) && $stable(lo_a)));
   // R8: an idle engine sits low
   p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !fclk);
endmodule

// File: rtl/sdcg_out_stage.sv
// Output stage: follows the fast clock in normal mode, divides it in slow
// mode. Mode and slow count are captured only when the output rises.
module sdcg_out_stage
   import sdcg_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gen_busy,
   input  logic             f_rise,
   input  logic             f_fall,
   input  sdcg_mode_e       mode_req,
   input  logic [DIV_W-1:0] div_req,
   output logic             sd_clk,
   output logic             rise_stb,
   output logic             fall_stb
);
   localparam int HALF_W = DIV_W - 1;
   localparam logic [HALF_W-1:0] HALF_ONE = HALF_W'(1);

   if (DIV_W < 3) begin : g_bad_div_w
      $error("sdcg_out_stage: DIV_W must be at least 3");
   end

   logic [HALF_W-1:0] half_raw, half_req, half_a, scnt_q;
   sdcg_mode_e        mode_a;
   logic              start, go_up, go_dn, slow_hit;

   assign half_raw = div_req[DIV_W-1:1];
   assign half_req = (half_raw == '0) ? HALF_ONE : half_raw;
   assign start    = f_rise && !gen_busy;
   assign slow_hit = (scnt_q == half_a - HALF_ONE);

   always_comb begin
      go_up = 1'b0;
      go_dn = 1'b0;
      if (f_rise) begin
         if (start || mode_a == SDCG_FAST) begin
            go_up = 1'b1;
         end else if (slow_hit) begin
            go_up = !sd_clk;
            go_dn = sd_clk;
         end
      end
      if (f_fall && mode_a == SDCG_FAST) begin
         go_dn = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sd_clk   <= 1'b0;
         rise_stb <= 1'b0;
         fall_stb <= 1'b0;
         mode_a   <= SDCG_FAST;
         half_a   <= HALF_ONE;
         scnt_q   <= '0;
      end else begin
         rise_stb <= go_up;
         fall_stb <= go_dn;
         if (go_up) begin
            sd_clk <= 1'b1;
            mode_a <= mode_req;
            half_a <= half_req;
            scnt_q <= '0;
         end else if (go_dn) begin
            sd_clk <= 1'b0;
            scnt_q <= '0;
         end else if (!gen_busy) begin
            scnt_q <= '0;
         end else if (f_rise && mode_a == SDCG_SLOW) begin
            scnt_q <= scnt_q + 1'b1;
         end
      end
   end

   // R4: strobes mark real edges and never coincide
   p_rise_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb |-> (sd_clk && !$past(sd_clk)));
   p_fall_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fall_stb |-> (!sd_clk && $past(sd_clk)));
   p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_stb && fall_stb));
   // R7: mode is only re-captured at an output rising edge
   p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rise_stb |-> ($stable(mode_a) && $stable(half_a)));
   // R6: slow counter stays inside its half period
   p_slow_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_a == SDCG_SLOW) |-> (scnt_q < half_a));
endmodule

// File: rtl/sdclk_duty_gen.sv
module sdclk_duty_gen
   import sdcg_pkg::*;
#(
   parameter int PH_W    = 4,
   parameter int DIV_W   = 8,
   parameter bit SLOW_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             slow_sel,
   input  logic [PH_W-1:0]  hi_len,
   input  logic [PH_W-1:0]  lo_len,
   input  logic [DIV_W-1:0] slow_div,
   output logic             sd_clk,
   output logic             rise_stb,
   output logic             fall_stb
);
   logic       fclk, gen_busy, f_rise, f_fall, run;
   sdcg_mode_e mode_req;

   // keep the engine alive while the output is high: no truncated high phase
   assign run = en || sd_clk;

   if (SLOW_EN) begin : g_slow
      assign mode_req = slow_sel ? SDCG_SLOW : SDCG_FAST;
   end else begin : g_fast_only
      assign mode_req = SDCG_FAST;
   end

   sdcg_phase_gen #(.PH_W(PH_W)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .hi_len   (hi_len),
      .lo_len   (lo_len),
      .fclk     (fclk),
      .busy     (gen_busy),
      .rise_nxt (f_rise),
      .fall_nxt (f_fall)
   );

   sdcg_out_stage #(.DIV_W(DIV_W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .gen_busy (gen_busy),
      .f_rise   (f_rise),
      .f_fall   (f_fall),
      .mode_req (mode_req),
      .div_req  (slow_div),
      .sd_clk   (sd_clk),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   // R2: idle generator with enable starts a high phase on the next edge
   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!gen_busy && en) |=> (sd_clk && rise_stb));
   // R8: no rising edge unless enable was present
   p_rise_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb |-> $past(en));
   // R8: idle generator means a low output
   p_idle_out_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_busy |-> !sd_clk);
   // R3: in normal mode the output tracks the fast engine
   p_fast_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fclk && !sd_clk) |-> (u_out.mode_a == SDCG_SLOW));
endmodule

// File: tb/test_sdclk_duty_gen.sv
module test_sdclk_duty_gen;
   localparam int CLK_PERIOD = 10;
   localparam int WD_LIMIT   = 100000;

   typedef struct packed {
      logic [3:0] hi;
      logic [3:0] lo;
      logic       slow;
      logic [7:0] div;
      logic [7:0] eh;
      logic [7:0] el;
   } vec_t;

   // expected: normal eh=hi+1, el=lo+1; slow eh=el=H*(hi+lo+2), H=max(div/2,1)
   localparam vec_t VTAB [8] = '{
      '{hi:4'd3,  lo:4'd0,  slow:1'b0, div:8'd0,  eh:8'd4,  el:8'd1},
      '{hi:4'd0,  lo:4'd0,  slow:1'b0, div:8'd0,  eh:8'd1,  el:8'd1},
      '{hi:4'd15, lo:4'd15, slow:1'b0, div:8'd0,  eh:8'd16, el:8'd16},
      '{hi:4'd1,  lo:4'd6,  slow:1'b0, div:8'd9,  eh:8'd2,  el:8'd7},
      '{hi:4'd3,  lo:4'd0,  slow:1'b1, div:8'd10, eh:8'd25, el:8'd25},
      '{hi:4'd0,  lo:4'd0,  slow:1'b1, div:8'd6,  eh:8'd6,  el:8'd6},
      '{hi:4'd1,  lo:4'd1,  slow:1'b1, div:8'd1,  eh:8'd4,  el:8'd4},
      '{hi:4'd2,  lo:4'd1,  slow:1'b1, div:8'd7,  eh:8'd15, el:8'd15}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       slow_sel = 1'b0;
   logic [3:0] hi_len = '0;
   logic [3:0] lo_len = '0;
   logic [7:0] slow_div = '0;
   logic       sd_clk, rise_stb, fall_stb;

   int checks = 0;
   int failures = 0;
   int strobe_bad = 0;
   int cyc = 0;
   logic prev_sd = 1'b0;

   sdclk_duty_gen i_sdclk_duty_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .slow_sel (slow_sel),
      .hi_len   (hi_len),
      .lo_len   (lo_len),
      .slow_div (slow_div),
      .sd_clk   (sd_clk),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == WD_LIMIT) begin
         failures++;
         $display("FAIL watchdog: actual cycles=%0d expected below %0d", cyc, WD_LIMIT);
         finish_run();
      end
   end

   // R4 monitor: strobes against observed output transitions
   always @(negedge clk) begin
      if (rst_n) begin
         if (rise_stb !== (sd_clk && !prev_sd) || fall_stb !== (!sd_clk && prev_sd) ||
             (rise_stb && fall_stb))
            strobe_bad++;
      end
      prev_sd = sd_clk;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_rise();
      int t = 0;
      while (rise_stb !== 1'b1 && t < 1000) begin
         @(negedge clk);
         t++;
      end
   endtask

   task automatic count_period(output int h, output int l);
      h = 0;
      while (sd_clk === 1'b1 && h < 400) begin
         h++;
         @(negedge clk);
      end
      l = 0;
      while (sd_clk === 1'b0 && l < 400) begin
         l++;
         @(negedge clk);
      end
   endtask

   task automatic go_idle();
      @(negedge clk);
      en = 1'b0;
      repeat (600) @(negedge clk);
   endtask

   initial begin
      int h, l;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 sd_clk in reset", int'(sd_clk), 0);
      chk("R1 strobes in reset", int'(rise_stb) + int'(fall_stb), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1 sd_clk idle after reset", int'(sd_clk), 0);

      // R2: start latency from idle
      hi_len = 4'd2; lo_len = 4'd2;
      en = 1'b1;
      @(negedge clk);
      chk("R2 sd_clk high after first enabled edge", int'(sd_clk), 1);
      chk("R2 rise strobe on start", int'(rise_stb), 1);

      // R3 / R6 / R9: table of settings
      foreach (VTAB[i]) begin
         go_idle();
         hi_len = VTAB[i].hi; lo_len = VTAB[i].lo;
         slow_sel = VTAB[i].slow; slow_div = VTAB[i].div;
         en = 1'b1;
         @(negedge clk);
         wait_rise();
         count_period(h, l);
         chk(VTAB[i].slow ? "R6 first high" : "R3 first high", h, int'(VTAB[i].eh));
         count_period(h, l);
         chk(VTAB[i].slow ? (VTAB[i].div < 2 ? "R9 high" : "R6 high") : "R3 high",
             h, int'(VTAB[i].eh));
         chk(VTAB[i].slow ? (VTAB[i].div < 2 ? "R9 low" : "R6 low") : "R3 low",
             l, int'(VTAB[i].el));
      end

      // R5: field change mid-period applies from the next rise
      go_idle();
      slow_sel = 1'b0; hi_len = 4'd3; lo_len = 4'd0;
      en = 1'b1;
      @(negedge clk);
      wait_rise();
      hi_len = 4'd1; lo_len = 4'd2;
      count_period(h, l);
      chk("R5 current high keeps old length", h, 4);
      chk("R5 current low keeps old length", l, 1);
      count_period(h, l);
      chk("R5 new high length", h, 2);
      chk("R5 new low length", l, 3);

      // R7: mode change mid-period applies from the next rise
      go_idle();
      slow_sel = 1'b0; hi_len = 4'd0; lo_len = 4'd0; slow_div = 8'd4;
      en = 1'b1;
      @(negedge clk);
      wait_rise();
      slow_sel = 1'b1;
      count_period(h, l);
      chk("R7 current period stays normal high", h, 1);
      chk("R7 current period stays normal low", l, 1);
      count_period(h, l);
      chk("R7 slow high after next rise", h, 4);
      chk("R7 slow low after next rise", l, 4);

      // R8: disable during a slow high phase completes it, then stays low
      go_idle();
      slow_sel = 1'b1; hi_len = 4'd0; lo_len = 4'd0; slow_div = 8'd6;
      en = 1'b1;
      @(negedge clk);
      wait_rise();
      @(negedge clk);
      @(negedge clk);
      en = 1'b0;
      h = 2;
      while (sd_clk === 1'b1 && h < 400) begin
         h++;
         @(negedge clk);
      end
      chk("R8 slow high completes after disable", h, 6);
      count_period(h, l);
      chk("R8 no rise while disabled", l, 400);

      // R8: disable during a normal high phase
      slow_sel = 1'b0; hi_len = 4'd5; lo_len = 4'd1;
      en = 1'b1;
      @(negedge clk);
      wait_rise();
      count_period(h, l);
      wait_rise();
      @(negedge clk);
      en = 1'b0;
      h = 1;
      while (sd_clk === 1'b1 && h < 400) begin
         h++;
         @(negedge clk);
      end
      chk("R8 normal high completes after disable", h, 6);
      repeat (50) @(negedge clk);
      chk("R8 output low when disabled", int'(sd_clk), 0);

      chk("R4 strobe mismatches", strobe_bad, 0);
      finish_run();
   end
endmodule